// File: doc/BRIEF.md
# Periodic Subclock Generator With Offset

This block turns a parent event stream into a slower periodic stream. Each clock cycle is one logical step, and every event is a strobe one cycle wide. The block ignores a fixed number of parent events at the start. After that it emits a tick together with every P-th parent event. The tick is combinational from the parent strobe, so a tick and the parent event that carries it are always in the same step. Steps with no parent event do not move the block's internal position.

The same instance also acts as a checker for an externally supplied tick stream. It keeps two sticky flags, which only reset clears. The strict flag is raised when the observed tick ever differs from the generated one. The weak flag is raised when the observed ticks break the window rule. Window i opens on the parent event that carries generated tick i and runs up to, but not including, the parent event that opens window i+1. Each window must hold exactly one observed tick. That tick may share a step with the opening parent event or fall anywhere later in the window, including steps with no parent event.

Top module: `periodic_subclock`

## Requirements
- R1: After reset, `tick_o`, `strict_err_o` and `weak_err_o` are all 0.
- R2: On the first OFFSET parent events after reset, `tick_o` stays 0. It is 1 on parent event number OFFSET+1, counted from 1.
- R3: After that first tick, `tick_o` is 1 on every PERIOD-th parent event and 0 on the parent events between them. Tick i coincides with parent event (i-1)*PERIOD+OFFSET+1.
- R4: In a step where `parent_i` is 0, `tick_o` is 0, and the block's position in the sequence is unchanged. Gaps of any length between parent events do not shift later ticks.
- R5: `tick_o` is asserted only in a step where `parent_i` is 1. It is combinational, with no cycle of latency.
- R6: With PERIOD=1 and OFFSET=0, `tick_o` equals `parent_i` in every step.
- R7: `strict_err_o` becomes 1 in the cycle after any step where `tick_i` differs from `tick_o`. It then stays 1 until reset.
- R8: `weak_err_o` becomes 1 in the cycle after a step where `tick_i` is 1 before the first window has opened. It is sticky until reset.
- R9: `weak_err_o` becomes 1 in the cycle after a second `tick_i` pulse inside the same window.
- R10: `weak_err_o` becomes 1 in the cycle after a parent event opens a new window while the previous window saw no `tick_i` pulse.
- R11: A single `tick_i` pulse is accepted without a weak error anywhere in its window. This includes a step coincident with the opening parent event and a later step with no parent event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parent_i | input | 1 | Parent event strobe |
| tick_i | input | 1 | Observed tick strobe to be checked |
| tick_o | output | 1 | Generated periodic tick |
| strict_err_o | output | 1 | Sticky strict-rule violation flag |
| weak_err_o | output | 1 | Sticky window-rule violation flag |

## Verification
The offset boundary is checked on the parent events numbered OFFSET and OFFSET+1. A design with an off-by-one skip count would fire one event early or late. Long idle gaps are placed between parent events to catch a counter that advances on empty steps, which would shift every later tick. For the weak rule, the bench places ticks before the first window, twice in one window, missing from a window, and late in a window on a step with no parent event. A design that mixed up the window boundaries would flag the legal late tick, or miss one of the illegal cases. A second instance with PERIOD=1 and OFFSET=0 must copy the parent stream exactly.

// File: rtl/periodic_subclock.sv
module periodic_subclock #(
  parameter int PERIOD = 3,
  parameter int OFFSET = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic parent_i,
  input  logic tick_i,
  output logic tick_o,
  output logic strict_err_o,
  output logic weak_err_o
);
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int SK_W = (OFFSET > 0) ? $clog2(OFFSET + 1) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [SK_W-1:0] SK_INIT = SK_W'(OFFSET);

  logic [SK_W-1:0] skip_q;
  logic [PH_W-1:0] phase_q;
  logic            opened_q, got_q;
  logic            skipping, weak_bad;

  assign skipping = (skip_q != '0);
  assign tick_o   = parent_i && !skipping && (phase_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q  <= SK_INIT;
      phase_q <= '0;
    end else if (parent_i) begin
      if (skipping)
        skip_q <= skip_q - 1'b1;
      else if (phase_q == PH_LAST)
        phase_q <= '0;
      else
        phase_q <= phase_q + 1'b1;
    end
  end

  always_comb begin
    if (tick_o) weak_bad = opened_q && !got_q;
    else        weak_bad = tick_i && (!opened_q || got_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opened_q     <= 1'b0;
      got_q        <= 1'b0;
      strict_err_o <= 1'b0;
      weak_err_o   <= 1'b0;
    end else begin
      if (tick_o) begin
        opened_q <= 1'b1;
        got_q    <= tick_i;
      end else if (tick_i) begin
        got_q <= 1'b1;
      end
      if (tick_i != tick_o) strict_err_o <= 1'b1;
      if (weak_bad)         weak_err_o   <= 1'b1;
    end
  end
endmodule

module periodic_subclock_chk (
  input logic clk,
  input logic rst_n,
  input logic parent_i,
  input logic tick_i,
  input logic tick_o,
  input logic strict_err_o,
  input logic weak_err_o
);
  AST_TICK_NEEDS_PARENT: assert property (@(posedge clk) disable iff (!rst_n) tick_o |-> parent_i); // R5
  AST_NO_PARENT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !parent_i |-> !tick_o); // R4
  AST_STRICT_SET: assert property (@(posedge clk) disable iff (!rst_n) (tick_i != tick_o) |=> strict_err_o); // R7
  AST_STRICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) strict_err_o |=> strict_err_o); // R7
  AST_WEAK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) weak_err_o |=> weak_err_o); // R8
endmodule

bind periodic_subclock periodic_subclock_chk chk_i (.*);

// File: tb/periodic_subclock_tb_top.sv
module periodic_subclock_tb_top;
  localparam int PER = 3;
  localparam int OFF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic parent = 1'b0;
  logic tick_in = 1'b0;
  logic tick_o, s_err, w_err;
  logic tick1, s1, w1;

  int checks = 0, errors = 0;
  int n;
  bit opened, got, m_s, m_w;

  always #5 clk = ~clk;

  periodic_subclock #(.PERIOD(PER), .OFFSET(OFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .parent_i(parent), .tick_i(tick_in),
    .tick_o(tick_o), .strict_err_o(s_err), .weak_err_o(w_err));

  periodic_subclock #(.PERIOD(1), .OFFSET(0)) dut1_i (
    .clk(clk), .rst_n(rst_n), .parent_i(parent), .tick_i(tick_in),
    .tick_o(tick1), .strict_err_o(s1), .weak_err_o(w1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit f_exp(input bit p);
    return p && (n >= OFF) && (((n - OFF) % PER) == 0);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; parent = 1'b0; tick_in = 1'b0;
    n = 0; opened = 0; got = 0; m_s = 0; m_w = 0;
    @(negedge clk); #1;
    chk(tick_o == 1'b0 && s_err == 1'b0 && w_err == 1'b0, "R1 reset", {tick_o, s_err, w_err}, 0);
    rst_n = 1'b1;
  endtask

  task automatic step(input bit p, input bit a);
    bit et;
    @(negedge clk);
    parent = p; tick_in = a;
    #1;
    et = f_exp(p);
    if (!p) chk(tick_o == 1'b0, "R4 idle step", tick_o, 0);
    else if (n < OFF) chk(tick_o == et, "R2 offset", tick_o, et);
    else chk(tick_o == et, "R3 period", tick_o, et);
    chk(tick1 == p, "R6 unit period", tick1, p);
    if (a != et) m_s = 1;
    if (et) begin
      if (opened && !got) m_w = 1;
      got = a; opened = 1;
    end else if (a) begin
      if (!opened || got) m_w = 1;
      got = 1;
    end
    if (p) n++;
    @(posedge clk); #1;
    chk(s_err == m_s, "R7 strict flag", s_err, m_s);
    chk(w_err == m_w, "R8/R9/R10/R11 weak flag", w_err, m_w);
  endtask

  task automatic good_parents(input int k);
    for (int i = 0; i < k; i++) begin
      step(1'b1, f_exp(1'b1));
      step(1'b0, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R2 R3 R4: random parents with long gaps, correct observed tick
    for (int i = 0; i < 300; i++) begin
      bit p;
      p = ($urandom % 3) == 0;
      if (($urandom % 17) == 0) for (int g = 0; g < 6; g++) step(1'b0, 1'b0);
      step(p, f_exp(p));
    end
    // R8: tick before the first window
    do_reset();
    step(1'b0, 1'b1);
    // R11: tick late in window on a non-parent step, weak stays clean
    do_reset();
    good_parents(OFF);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    good_parents(4);
    // R9: second tick in same window
    do_reset();
    good_parents(OFF + 1);
    step(1'b0, 1'b1);
    // R10: window closes without any tick
    do_reset();
    good_parents(OFF);
    step(1'b1, 1'b0);
    good_parents(PER);
    // random sparse observed ticks against the window model
    do_reset();
    for (int i = 0; i < 400; i++) begin
      bit p, a;
      p = ($urandom % 2) == 0;
      a = (($urandom % 8) == 0) ? 1'b1 : f_exp(p);
      step(p, a);
      if ((i % 100) == 99) do_reset();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule